// File: doc/BRIEF.md
# Handshake Line Edge Interrupt Detector

This block watches two handshake input lines, a primary line and a secondary line, and latches an interrupt flag for each when that line makes its selected transition. The line is sampled once per bus cycle on the bus clock. A transition is found by comparing each sample with the one taken in the cycle before. Each line has its own control bit that picks whether a falling or a rising transition counts.

The two flags are read back as the top two bits of an eight-bit control register. Software writes only the lower six configuration bits. The flags can be neither written nor cleared through that register. A read of the associated port data register, signalled by a one-cycle strobe, clears both flags. If a new active transition is seen in the same cycle as that read, the flag stays set.

An active-low interrupt request is asserted while any flag is set and its enable bit is 1. The secondary line can also be configured as an output. In that mode its transitions are not detected and its flag cannot raise the request.

Top module: `ctl_edge_irq`

## Requirements
- R1: While `rst_ni` is low, `ctl_rdata_o` reads 8'h00 and `irq_no` is 1.
- R2: A cycle with `ctl_wr_i` high stores `ctl_wdata_i` into bits 5:0 of the control register, visible on `ctl_rdata_o[5:0]` after that clock. Bits 7:6 keep their flag values.
- R3: A primary-line transition is active when control bit 1 matches its direction: 0 means falling, 1 means rising. The line is sampled at clock edge k. The bit-7 flag reads 1 after edge k+1, not after edge k, and it stays set until cleared. A transition in the other direction leaves the flag at 0.
- R4: A secondary-line transition sets the bit-6 flag with the same timing as R3. Control bit 4 selects its direction: 0 means falling, 1 means rising. It does not touch the bit-7 flag.
- R5: While control bit 5 is 1 (secondary line used as an output), no secondary-line transition of either direction sets the bit-6 flag.
- R6: A cycle with `port_rd_i` high and no active transition clears both flags at the following clock.
- R7: If an active transition is detected in the same cycle that `port_rd_i` is high, that line's flag reads 1 after the clock.
- R8: `irq_no` is 0 exactly when (bit 7 and bit 0 are both 1) or (bit 6 and bit 3 are both 1 and bit 5 is 0). Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; one cycle is one bus cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 6 | Configuration bits written to control bits 5:0 |
| port_rd_i | input | 1 | Port data register read strobe; clears flags |
| line_p_i | input | 1 | Primary handshake input line |
| line_s_i | input | 1 | Secondary handshake line, input side |
| ctl_rdata_o | output | 8 | Control register: flags in bits 7:6, configuration in 5:0 |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The assertions assume the lines and strobes are stable around each rising clock edge. They also assume a transition is judged from samples taken at least four clocks after reset, because the detector ignores its first two samples. The bench changes every input on the falling clock edge. It holds each line at its start level for several cycles and clears any flag that setting left behind before it makes the transition under test. Every expected flag is therefore caused by exactly one known transition.

// File: rtl/ctl_edge_pkg.sv
package ctl_edge_pkg;
  localparam int CTL_W   = 8;
  localparam int CFG_W   = 6;
  localparam int NLINES  = 2;
  localparam int WARMUP  = 2;  // samples needed before a comparison is trusted

  localparam int B_EN_P  = 0;
  localparam int B_POL_P = 1;
  localparam int B_EN_S  = 3;
  localparam int B_POL_S = 4;
  localparam int B_DIR_S = 5;
  localparam int B_FLG_S = 6;
  localparam int B_FLG_P = 7;

  localparam int L_P = 0;
  localparam int L_S = 1;

  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/edge_det.sv
module edge_det
  import ctl_edge_pkg::*;
#(
  parameter int WARM = WARMUP
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic pol_i,
  input  logic arm_i,
  output logic hit_o
);
  logic            cur_q, prev_q;
  logic [WARM-1:0] vld_q;
  edge_pol_e       pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
      vld_q  <= '0;
    end else begin
      cur_q  <= line_i;
      prev_q <= cur_q;
      vld_q  <= {vld_q[WARM-2:0], 1'b1};
    end
  end

  always_comb begin
    pol   = edge_pol_e'(pol_i);
    hit_o = 1'b0;
    if (vld_q[WARM-1] && arm_i) begin
      unique case (pol)
        POL_RISE: hit_o = cur_q & ~prev_q;
        POL_FALL: hit_o = ~cur_q & prev_q;
        default:  hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/ctl_cfg_reg.sv
module ctl_cfg_reg
  import ctl_edge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (wr_i) cfg_o <= wdata_i;
  end
endmodule

// File: rtl/ctl_edge_irq.sv
module ctl_edge_irq
  import ctl_edge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_wr_i,
  input  logic [CFG_W-1:0] ctl_wdata_i,
  input  logic             port_rd_i,
  input  logic             line_p_i,
  input  logic             line_s_i,
  output logic [CTL_W-1:0] ctl_rdata_o,
  output logic             irq_no
);
  logic [CFG_W-1:0]  cfg;
  logic [NLINES-1:0] line_vec, pol_vec, arm_vec, hit_vec, flag_vec;
  logic              req_p, req_s;

  ctl_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .cfg_o   (cfg)
  );

  assign line_vec[L_P] = line_p_i;
  assign line_vec[L_S] = line_s_i;
  assign pol_vec[L_P]  = cfg[B_POL_P];
  assign pol_vec[L_S]  = cfg[B_POL_S];
  assign arm_vec[L_P]  = 1'b1;
  assign arm_vec[L_S]  = ~cfg[B_DIR_S];  // output mode disables detection

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    edge_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_vec[i]),
      .pol_i  (pol_vec[i]),
      .arm_i  (arm_vec[i]),
      .hit_o  (hit_vec[i])
    );
    irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (hit_vec[i]),
      .clr_i  (port_rd_i),
      .flag_o (flag_vec[i])
    );
  end

  assign req_p = flag_vec[L_P] & cfg[B_EN_P];
  assign req_s = flag_vec[L_S] & cfg[B_EN_S] & ~cfg[B_DIR_S];

  assign ctl_rdata_o = {flag_vec[L_P], flag_vec[L_S], cfg};
  assign irq_no      = ~(req_p | req_s);
endmodule

// File: rtl/ctl_edge_irq_chk.sv
module ctl_edge_irq_chk
  import ctl_edge_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_wr_i,
  input logic [CFG_W-1:0] ctl_wdata_i,
  input logic             port_rd_i,
  input logic             line_p_i,
  input logic             line_s_i,
  input logic [CTL_W-1:0] ctl_rdata_o,
  input logic             irq_no
);
  logic [2:0] cyc_q;
  logic       ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 3'd7)   cyc_q <= cyc_q + 3'd1;
  end
  assign ok = (cyc_q >= 3'd4);

  always_comb begin
    if (!rst_ni) assert_reset_state_R1: assert (ctl_rdata_o == 8'h00 && irq_no);
  end

  assert_cfg_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ctl_wr_i) |-> ctl_rdata_o[CFG_W-1:0] == $past(ctl_wdata_i));

  assert_p_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && $past(line_p_i, 2) && !$past(line_p_i, 3) && $past(ctl_rdata_o[B_POL_P]))
    |-> ctl_rdata_o[B_FLG_P]);

  assert_p_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && !$past(line_p_i, 2) && $past(line_p_i, 3) && !$past(ctl_rdata_o[B_POL_P]))
    |-> ctl_rdata_o[B_FLG_P]);

  assert_s_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && $past(line_s_i, 2) && !$past(line_s_i, 3) && $past(ctl_rdata_o[B_POL_S])
     && !$past(ctl_rdata_o[B_DIR_S])) |-> ctl_rdata_o[B_FLG_S]);

  assert_s_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_rdata_o[B_FLG_S]) |-> !$past(ctl_rdata_o[B_DIR_S]));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok && $past(port_rd_i) && ($past(line_p_i, 2) == $past(line_p_i, 3)))
    |-> !ctl_rdata_o[B_FLG_P]);

  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> ((ctl_rdata_o[B_FLG_P] && ctl_rdata_o[B_EN_P]) ||
                 (ctl_rdata_o[B_FLG_S] && ctl_rdata_o[B_EN_S] && !ctl_rdata_o[B_DIR_S])));
endmodule

bind ctl_edge_irq ctl_edge_irq_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_wr_i    (ctl_wr_i),
  .ctl_wdata_i (ctl_wdata_i),
  .port_rd_i   (port_rd_i),
  .line_p_i    (line_p_i),
  .line_s_i    (line_s_i),
  .ctl_rdata_o (ctl_rdata_o),
  .irq_no      (irq_no)
);

// File: tb/ctl_edge_irq_tb_top.sv
`timescale 1ns/1ps
module ctl_edge_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [5:0] ctl_wd = '0;
  logic       port_rd = 1'b0;
  logic       line_p = 1'b0;
  logic       line_s = 1'b0;
  logic [7:0] rdata;
  logic       irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ctl_edge_irq dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ctl_wr_i    (ctl_wr),
    .ctl_wdata_i (ctl_wd),
    .port_rd_i   (port_rd),
    .line_p_i    (line_p),
    .line_s_i    (line_s),
    .ctl_rdata_o (rdata),
    .irq_no      (irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_write(input logic [5:0] v);
    ctl_wr = 1'b1;
    ctl_wd = v;
    tick();
    ctl_wr = 1'b0;
  endtask

  task automatic port_read();
    port_rd = 1'b1;
    tick();
    port_rd = 1'b0;
  endtask

  task automatic settle(input logic p, input logic s);
    line_p = p;
    line_s = s;
    repeat (3) tick();
    port_read();
  endtask

  task automatic t_reset();
    chk("R1 rdata in reset", rdata, 8'h00);
    chk("R1 irq_no in reset", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_cfg_write();
    ctl_write(6'h3F);
    chk("R2 write all ones", rdata, 8'h3F);
    ctl_write(6'h12);
    chk("R2 write pattern", rdata, 8'h12);
    ctl_write(6'h00);
    chk("R2 write zero", rdata, 8'h00);
  endtask

  task automatic t_primary_fall();
    ctl_write(6'h00);
    settle(1'b1, 1'b0);
    chk("R6 flags clear after settle", rdata, 8'h00);
    line_p = 1'b0;
    tick();
    chk("R3 not yet after sample edge", {7'b0, rdata[7]}, 8'h00);
    tick();
    chk("R3 falling sets bit7", rdata, 8'h80);
    repeat (3) tick();
    chk("R3 flag latched", rdata, 8'h80);
    port_read();
    chk("R6 read clears bit7", rdata, 8'h00);
  endtask

  task automatic t_primary_rise();
    ctl_write(6'h02);
    settle(1'b1, 1'b0);
    line_p = 1'b0;
    repeat (3) tick();
    chk("R3 falling ignored when rising selected", rdata, 8'h02);
    line_p = 1'b1;
    repeat (2) tick();
    chk("R3 rising sets bit7", rdata, 8'h82);
    port_read();
  endtask

  task automatic t_secondary();
    ctl_write(6'h00);
    settle(1'b0, 1'b1);
    line_s = 1'b0;
    repeat (2) tick();
    chk("R4 falling sets bit6 only", rdata, 8'h40);
    port_read();
    chk("R6 read clears bit6", rdata, 8'h00);
    ctl_write(6'h10);
    settle(1'b0, 1'b0);
    line_s = 1'b1;
    repeat (2) tick();
    chk("R4 rising sets bit6", rdata, 8'h50);
    port_read();
  endtask

  task automatic t_sec_output();
    ctl_write(6'h30);
    settle(1'b0, 1'b0);
    line_s = 1'b1;
    repeat (3) tick();
    chk("R5 rising ignored in output mode", rdata, 8'h30);
    ctl_write(6'h20);
    line_s = 1'b0;
    repeat (3) tick();
    chk("R5 falling ignored in output mode", rdata, 8'h20);
  endtask

  task automatic t_write_keeps_flags();
    ctl_write(6'h00);
    settle(1'b1, 1'b1);
    line_p = 1'b0;
    line_s = 1'b0;
    repeat (2) tick();
    chk("R3 R4 both flags", rdata, 8'hC0);
    ctl_write(6'h04);
    chk("R2 write keeps flags", rdata, 8'hC4);
    port_read();
    chk("R6 read clears both", rdata, 8'h04);
  endtask

  task automatic t_collide();
    ctl_write(6'h00);
    settle(1'b1, 1'b0);
    line_p = 1'b0;
    tick();
    port_rd = 1'b1;
    tick();
    port_rd = 1'b0;
    chk("R7 edge with read keeps flag", rdata, 8'h80);
    port_read();
    chk("R6 later read clears", rdata, 8'h00);
  endtask

  task automatic t_irq();
    ctl_write(6'h00);
    settle(1'b1, 1'b1);
    line_p = 1'b0;
    line_s = 1'b0;
    repeat (2) tick();
    chk("R8 flags set but disabled", {7'b0, irq_n}, 8'h01);
    ctl_write(6'h01);
    chk("R8 primary enable", {7'b0, irq_n}, 8'h00);
    ctl_write(6'h08);
    chk("R8 secondary enable", {7'b0, irq_n}, 8'h00);
    ctl_write(6'h28);
    chk("R8 output mode masks secondary", {7'b0, irq_n}, 8'h01);
    chk("R5 flag6 kept in output mode", rdata, 8'hE8);
    ctl_write(6'h09);
    port_read();
    chk("R8 released after clear", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) tick();
    t_cfg_write();
    t_primary_fall();
    t_primary_rise();
    t_secondary();
    t_sec_output();
    t_write_keeps_flags();
    t_collide();
    t_irq();
    finish_run();
  end

  initial begin
    #(8 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule